// File: doc/BRIEF.md
# ECC Memory Termination Responder

This block sits on the slave side of a RAM whose read data is checked by an error-detecting circuit. It watches the bus master's active-low cycle strobe and a result interface from the checker. From these it drives three active-low lines back to the master: acknowledge, bus error and halt. A 2-bit policy input decides when the acknowledge is given and how a data error is reported.

Under the two verify-first policies, the acknowledge waits for the checker. Under the two early policies, the acknowledge is given at once and any error is raised one clock after the checker reports it. An error is reported either as a retry request (bus error together with halt) or as an exception request (bus error alone). Correction of the RAM contents is not part of the block. It is represented only by a one-clock correction-request pulse that is raised with every retry-type error.

Top module: `ecc_term_resp`

## Requirements
- R1: While rst_ni is low and after its release, ack_n_o, berr_n_o and halt_n_o are high and fix_req_o is low until a cycle starts.
- R2: A cycle starts on the first rising clock edge at which cyc_n_i is sampled low while the block is idle. mode_i is captured at that edge, and later changes of mode_i have no effect until the next cycle. Encoding: bit 1 = early acknowledge, bit 0 = retry on error (00 verify/exception, 01 verify/retry, 10 early/exception, 11 early/retry).
- R3: In the verify-first modes, ack_n_o stays high until the checker result. On a good result (chk_bad_i low), ack_n_o goes low after the edge at which chk_valid_i is sampled high, and berr_n_o and halt_n_o stay high.
- R4: In mode 01, a bad result drives berr_n_o and halt_n_o low together after that edge, and ack_n_o stays high.
- R5: In mode 00, a bad result drives berr_n_o low after that edge, while ack_n_o and halt_n_o stay high.
- R6: In the early modes (10, 11), ack_n_o goes low after the cycle-start edge, before any checker result. On a good result nothing else changes.
- R7: In mode 10, a bad result adds berr_n_o low on the next clock, ack_n_o stays low and halt_n_o stays high.
- R8: In mode 11, a bad result adds berr_n_o and halt_n_o low on the next clock, and ack_n_o stays low.
- R9: fix_req_o is high for exactly one clock, in the same cycle that halt_n_o first goes low for a retry-mode error, and at no other time.
- R10: Every asserted line stays asserted while cyc_n_i is low. At the edge where cyc_n_i is sampled high, all three lines are released together, including when no result has arrived yet.
- R11: A checker strobe while the block is idle, or after a cycle's result was already taken, has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_n_i | input | 1 | Master cycle strobe, active low |
| mode_i | input | 2 | Termination policy, captured at cycle start |
| chk_valid_i | input | 1 | One-clock checker result strobe |
| chk_bad_i | input | 1 | Checker result, high = data error |
| ack_n_o | output | 1 | Acknowledge, active low |
| berr_n_o | output | 1 | Bus error, active low |
| halt_n_o | output | 1 | Halt, active low |
| fix_req_o | output | 1 | One-clock correction request |

## Verification
All four policies are exercised with both good and bad checker results and with checker latencies of one to four clocks. This separates the acknowledge timing of the verify-first and early groups, and the retry and exception signalling within each group. Some cycles flip mode_i after the cycle has started, which shows whether the policy is really latched. Stray strobes of the opposite polarity, sent after the result and during idle, show whether late checker activity can disturb the lines. A directed case releases the strobe before any result arrives, which tests the release path on its own.

// File: rtl/ecc_term_pkg.sv
package ecc_term_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    POL_VF_EXC = 2'b00,
    POL_VF_RTY = 2'b01,
    POL_EA_EXC = 2'b10,
    POL_EA_RTY = 2'b11
  } policy_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } state_e;

  typedef struct packed {
    logic ack;
    logic berr;
    logic halt;
    logic fix;
  } term_t;

  function automatic logic is_early(policy_e p);
    return p[1];
  endfunction

  function automatic logic is_retry(policy_e p);
    return p[0];
  endfunction
endpackage

// File: rtl/ecc_term_fsm.sv
module ecc_term_fsm
  import ecc_term_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_n_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              chk_valid_i,
  output logic              start_o,
  output logic              result_o,
  output logic              release_o,
  output policy_e           pol_eff_o,
  output policy_e           pol_q_o
);
  state_e  state_q, state_d;
  policy_e pol_q;

  assign start_o   = (state_q == ST_IDLE) && !cyc_n_i;
  assign result_o  = (state_q == ST_WAIT) && !cyc_n_i && chk_valid_i;
  assign release_o = (state_q != ST_IDLE) && cyc_n_i;
  // policy in force this clock: live input on the start edge, latched after
  assign pol_eff_o = start_o ? policy_e'(mode_i) : pol_q;
  assign pol_q_o   = pol_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (!cyc_n_i) state_d = ST_WAIT;
      ST_WAIT: begin
        if (cyc_n_i)          state_d = ST_IDLE;
        else if (chk_valid_i) state_d = ST_HOLD;
      end
      ST_HOLD: if (cyc_n_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pol_q   <= POL_VF_EXC;
    end else begin
      state_q <= state_d;
      if (start_o) pol_q <= policy_e'(mode_i);
    end
  end
endmodule

// File: rtl/ecc_term_policy.sv
module ecc_term_policy
  import ecc_term_pkg::*;
(
  input  policy_e pol_i,
  input  logic    start_i,
  input  logic    result_i,
  input  logic    bad_i,
  output term_t   set_o
);
  always_comb begin
    set_o = '0;
    if (start_i) begin
      set_o.ack = is_early(pol_i);
    end else if (result_i) begin
      if (!bad_i) begin
        set_o.ack = 1'b1;
      end else begin
        set_o.berr = 1'b1;
        set_o.halt = is_retry(pol_i);
        set_o.fix  = is_retry(pol_i);
      end
    end
  end
endmodule

// File: rtl/ecc_term_lines.sv
module ecc_term_lines #(
  parameter int N_LINES = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] set_i,
  input  logic               fix_i,
  input  logic               clr_i,
  output logic [N_LINES-1:0] line_n_o,
  output logic               fix_o
);
  logic [N_LINES-1:0] act_q;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       act_q[g] <= 1'b0;
      else if (clr_i)    act_q[g] <= 1'b0;
      else if (set_i[g]) act_q[g] <= 1'b1;
    end
    assign line_n_o[g] = ~act_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fix_o <= 1'b0;
    else         fix_o <= fix_i && !clr_i;
  end
endmodule

// File: rtl/ecc_term_resp.sv
module ecc_term_resp
  import ecc_term_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_n_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              chk_valid_i,
  input  logic              chk_bad_i,
  output logic              ack_n_o,
  output logic              berr_n_o,
  output logic              halt_n_o,
  output logic              fix_req_o
);
  localparam int N_LINES = 3;

  logic    start, result, rel;
  policy_e pol_eff, pol_q;
  term_t   set;
  logic [N_LINES-1:0] line_n;

  ecc_term_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_n_i    (cyc_n_i),
    .mode_i     (mode_i),
    .chk_valid_i(chk_valid_i),
    .start_o    (start),
    .result_o   (result),
    .release_o  (rel),
    .pol_eff_o  (pol_eff),
    .pol_q_o    (pol_q)
  );

  ecc_term_policy u_pol (
    .pol_i   (pol_eff),
    .start_i (start),
    .result_i(result),
    .bad_i   (chk_bad_i),
    .set_o   (set)
  );

  ecc_term_lines #(.N_LINES(N_LINES)) u_lines (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   ({set.ack, set.berr, set.halt}),
    .fix_i   (set.fix),
    .clr_i   (rel),
    .line_n_o(line_n),
    .fix_o   (fix_req_o)
  );

  assign ack_n_o  = line_n[2];
  assign berr_n_o = line_n[1];
  assign halt_n_o = line_n[0];
endmodule

// File: rtl/ecc_term_chk.sv
module ecc_term_chk
  import ecc_term_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    cyc_n_i,
  input logic    ack_n_o,
  input logic    berr_n_o,
  input logic    halt_n_o,
  input logic    fix_req_o,
  input policy_e pol_q
);
  // R4
  halt_with_berr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_n_o |-> !berr_n_o);

  // R4
  vf_retry_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_q == POL_VF_RTY && !halt_n_o) |-> ack_n_o);

  // R9
  fix_one_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_req_o |=> !fix_req_o);

  // R9
  fix_with_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_req_o |-> (!halt_n_o && !berr_n_o));

  // R10
  release_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_n_i |=> (ack_n_o && berr_n_o && halt_n_o));

  // R10
  ack_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cyc_n_i && !ack_n_o) |=> !ack_n_o);

  // R10
  berr_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cyc_n_i && !berr_n_o) |=> !berr_n_o);
endmodule

bind ecc_term_resp ecc_term_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cyc_n_i  (cyc_n_i),
  .ack_n_o  (ack_n_o),
  .berr_n_o (berr_n_o),
  .halt_n_o (halt_n_o),
  .fix_req_o(fix_req_o),
  .pol_q    (pol_q)
);

// File: tb/ecc_term_resp_tb_top.sv
module ecc_term_resp_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_n = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       chk_valid = 1'b0;
  logic       chk_bad = 1'b0;
  logic       ack_n, berr_n, halt_n, fix_req;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  ecc_term_resp dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cyc_n_i    (cyc_n),
    .mode_i     (mode),
    .chk_valid_i(chk_valid),
    .chk_bad_i  (chk_bad),
    .ack_n_o    (ack_n),
    .berr_n_o   (berr_n),
    .halt_n_o   (halt_n),
    .fix_req_o  (fix_req)
  );

  // expected {ack, berr, halt, fix} (asserted = 1) right after the result edge
  function automatic logic [3:0] exp_result(logic [1:0] m, logic bad);
    if (!bad) return 4'b1000;
    return {m[1], 1'b1, m[0], m[0]};
  endfunction

  function automatic string res_tag(logic [1:0] m, logic bad);
    if (!bad) return m[1] ? "R6" : "R3";
    case (m)
      2'b00:   return "R5";
      2'b01:   return "R4/R9";
      2'b10:   return "R7";
      default: return "R8/R9";
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] exp);
    logic [3:0] act;
    act = {~ack_n, ~berr_n, ~halt_n, fix_req};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {ack,berr,halt,fix} act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic run_cycle(logic [1:0] m, int lat, logic bad, bit flip, bit stray, int hold);
    logic [3:0] e;
    @(negedge clk);
    cyc_n = 1'b0;
    mode  = m;
    @(negedge clk);
    if (flip) mode = ~m;
    check(m[1] ? "R6 early ack" : "R3 ack held off", {m[1], 3'b000});
    for (int i = 1; i < lat; i++) begin
      @(negedge clk);
      check("R2/R3 waiting", {m[1], 3'b000});
    end
    chk_valid = 1'b1;
    chk_bad   = bad;
    @(negedge clk);
    chk_valid = 1'b0;
    e = exp_result(m, bad);
    check(res_tag(m, bad), e);
    if (stray) begin
      chk_valid = 1'b1;
      chk_bad   = ~bad;
    end
    @(negedge clk);
    chk_valid = 1'b0;
    e[0] = 1'b0;
    check(stray ? "R11 late strobe" : "R9/R10 hold", e);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R10 held", e);
    end
    cyc_n = 1'b1;
    @(negedge clk);
    check("R10 release", 4'b0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd20240611);
    repeat (2) @(negedge clk);
    check("R1 in reset", 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 4'b0000);

    // directed: every policy, good and bad, one-clock latency
    for (int m = 0; m < 4; m++) begin
      run_cycle(2'(m), 1, 1'b0, 1'b0, 1'b0, 0);
      run_cycle(2'(m), 1, 1'b1, 1'b0, 1'b0, 1);
    end

    // directed: idle strobe ignored
    @(negedge clk);
    chk_valid = 1'b1; chk_bad = 1'b1;
    @(negedge clk);
    chk_valid = 1'b0;
    check("R11 idle strobe", 4'b0000);

    // directed: release before result, then late strobe ignored
    @(negedge clk);
    cyc_n = 1'b0; mode = 2'b01;
    @(negedge clk);
    check("R3 abort wait", 4'b0000);
    cyc_n = 1'b1;
    @(negedge clk);
    check("R10 abort release", 4'b0000);
    chk_valid = 1'b1; chk_bad = 1'b1;
    @(negedge clk);
    chk_valid = 1'b0;
    check("R11 strobe after abort", 4'b0000);

    // directed: early mode released before result
    @(negedge clk);
    cyc_n = 1'b0; mode = 2'b11;
    @(negedge clk);
    check("R6 early abort", 4'b1000);
    cyc_n = 1'b1;
    @(negedge clk);
    check("R10 early abort release", 4'b0000);

    // directed: mode flipped mid-cycle
    run_cycle(2'b00, 2, 1'b1, 1'b1, 1'b0, 0);
    run_cycle(2'b11, 3, 1'b1, 1'b1, 1'b1, 0);

    // random
    for (int k = 0; k < 400; k++) begin
      run_cycle(2'($urandom_range(0, 3)), int'($urandom_range(1, 4)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
      if ($urandom_range(0, 3) == 0) begin
        chk_valid = 1'b1; chk_bad = 1'($urandom_range(0, 1));
        @(negedge clk);
        chk_valid = 1'b0;
        check("R11 idle random strobe", 4'b0000);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule